// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block drives a display backlight pin with a pulse-width-modulated waveform. It runs from a fixed reference clock. Two cascaded counters set the period. The first is a linear pre-divider of programmable modulus F. The second is a binary step counter that is Pn bits wide. One period therefore lasts F × 2^Pn reference clocks. At a 27 MHz reference, the output frequency is 27 MHz / (F × 2^Pn).

The width of the step counter also sets the brightness resolution, which is Pn bits. A longer period therefore gives finer brightness steps. The bit count Pn is clamped into a window that the panel reports through a lower and an upper bound.

All three settings (pre-divider, bit count and duty level) are copied into shadow registers only at a period boundary, so software may change them at any time without creating a short or broken period. A strobe marks the first clock of every period. When the enable input is low, the output is held low and every counter is cleared.

Top module: `bl_pwm_gen`

## Requirements
- R1: While enabled, one period lasts F × 2^Pn clock cycles, and `strobe_o` is high for exactly the first cycle of each period.
- R2: A pre-divider value of 0 behaves exactly like a value of 1.
- R3: The applied bit count is first limited to at most `pn_max_i` and then raised to at least `pn_min_i`, so the lower bound wins when the bounds cross.
- R4: The duty level is the low Pn bits of `duty_i`. The output is high while the step counter is below that level, which gives duty × F high cycles at the start of every period.
- R5: A duty level of 0 keeps the output low for the whole period. An all-ones duty level keeps the output high for all but the last F cycles.
- R6: A change to F, Pn, the bounds or the duty level in the middle of a period leaves that period untouched and takes effect from the next period.
- R7: While `en_i` is low, `pwm_o` and `strobe_o` stay low from the following cycle onward. When `en_i` is sampled high, the next cycle begins a fresh period, using the settings present at that clock edge.
- R8: With Pn equal to 0, the period is F cycles and the output stays low, because there are no duty bits.
- R9: During and right after reset, `pwm_o` and `strobe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable |
| pre_i | input | PRE_W (8) | Pre-divider modulus F |
| pn_i | input | PN_W (5) | Requested bit count Pn |
| pn_min_i | input | PN_W (5) | Lowest bit count the panel supports |
| pn_max_i | input | PN_W (5) | Highest bit count the panel supports |
| duty_i | input | 2^PN_W−1 (31) | Duty level; only the low Pn bits are used |
| pwm_o | output | 1 | Backlight PWM output |
| strobe_o | output | 1 | High on the first cycle of each period |

## Verification
The bench measures whole periods between strobes and counts the high cycles in each. A wrong cascade or an off-by-one in either counter shows up as a period that is not F × 2^Pn, or as a high time that is not duty × F.

Several corner cases each get their own scenario:
- A pre-divider of zero, which a careless design would turn into a 256-cycle stage.
- Bit counts below, above and across the capability bounds, where the wrong clamp order would pick the upper bound.
- Duty values of zero and all-ones, where a compare of the wrong sense makes the output stick high or lose its final low step.
- Bit count zero, where the output must stay low.

A mid-period rewrite checks that the running period keeps its old length, which an unshadowed design would cut short. A disable with the duty level at full checks that the pin drops at once.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
   // run state of the generator
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;
endpackage

// File: rtl/bl_pwm_cfg_shadow.sv
module bl_pwm_cfg_shadow #(
   parameter int PRE_W           = 8,
   parameter int PN_W            = 5,
   parameter bit ZERO_PRE_AS_ONE = 1'b1,
   localparam int RES_W          = (1 << PN_W) - 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [PRE_W-1:0] pre_i,
   input  logic [PN_W-1:0]  pn_i,
   input  logic [PN_W-1:0]  pn_min_i,
   input  logic [PN_W-1:0]  pn_max_i,
   input  logic [RES_W-1:0] duty_i,
   output logic [PRE_W-1:0] pre_q,
   output logic [PN_W-1:0]  pn_q,
   output logic [RES_W-1:0] top_q,
   output logic [RES_W-1:0] duty_q
);
   logic [PRE_W-1:0] pre_fix;
   logic [PN_W-1:0]  pn_cap;
   logic [PN_W-1:0]  pn_fix;
   logic [RES_W-1:0] top_fix;

   generate
      if (ZERO_PRE_AS_ONE) begin : g_zero_one
         assign pre_fix = (pre_i == '0) ? PRE_W'(1) : pre_i;
      end else begin : g_zero_full
         // zero wraps the pre-divider through its full range
         assign pre_fix = pre_i;
      end
   endgenerate

   // upper bound first, then the lower bound has the last word
   assign pn_cap  = (pn_i > pn_max_i) ? pn_max_i : pn_i;
   assign pn_fix  = (pn_cap < pn_min_i) ? pn_min_i : pn_cap;
   assign top_fix = ~({RES_W{1'b1}} << pn_fix);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q  <= PRE_W'(1);
         pn_q   <= '0;
         top_q  <= '0;
         duty_q <= '0;
      end else if (load_i) begin
         pre_q  <= pre_fix;
         pn_q   <= pn_fix;
         top_q  <= top_fix;
         duty_q <= duty_i & top_fix;
      end
   end
endmodule

// File: rtl/bl_pwm_prediv.sv
module bl_pwm_prediv #(
   parameter int PRE_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic [PRE_W-1:0] modulus_i,
   output logic             tick_o,
   output logic             at_zero_o
);
   logic [PRE_W-1:0] cnt_q;

   assign tick_o    = run_i && (cnt_q == modulus_i - PRE_W'(1));
   assign at_zero_o = (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (tick_o)  cnt_q <= '0;
      else if (run_i)   cnt_q <= cnt_q + PRE_W'(1);
   end
endmodule

// File: rtl/bl_pwm_step.sv
module bl_pwm_step #(
   parameter int RES_W = 31
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [RES_W-1:0] top_i,
   input  logic [RES_W-1:0] duty_i,
   output logic             wrap_o,
   output logic             at_zero_o,
   output logic             high_o
);
   logic [RES_W-1:0] step_q;

   assign wrap_o    = tick_i && (step_q == top_i);
   assign at_zero_o = (step_q == '0);
   assign high_o    = run_i && (step_q < duty_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      step_q <= '0;
      else if (clr_i)   step_q <= '0;
      else if (wrap_o)  step_q <= '0;
      else if (tick_i)  step_q <= step_q + RES_W'(1);
   end
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
   import bl_pwm_pkg::*;
#(
   parameter int PRE_W           = 8,
   parameter int PN_W            = 5,
   parameter bit ZERO_PRE_AS_ONE = 1'b1,
   localparam int RES_W          = (1 << PN_W) - 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [PRE_W-1:0] pre_i,
   input  logic [PN_W-1:0]  pn_i,
   input  logic [PN_W-1:0]  pn_min_i,
   input  logic [PN_W-1:0]  pn_max_i,
   input  logic [RES_W-1:0] duty_i,
   output logic             pwm_o,
   output logic             strobe_o
);
   generate
      if (PRE_W < 1 || PRE_W > 16) begin : g_bad_pre
         $error("bl_pwm_gen: PRE_W must be 1..16");
      end
      if (PN_W < 1 || PN_W > 5) begin : g_bad_pn
         $error("bl_pwm_gen: PN_W must be 1..5");
      end
   endgenerate

   phase_e           phase_q;
   logic             run_w;
   logic             clr_w;
   logic             load_w;
   logic             tick_w;
   logic             pre_zero_w;
   logic             step_zero_w;
   logic             period_end_w;
   logic [PRE_W-1:0] pre_q;
   logic [PN_W-1:0]  pn_q;
   logic [RES_W-1:0] top_q;
   logic [RES_W-1:0] duty_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) phase_q <= PH_IDLE;
      else         phase_q <= en_i ? PH_RUN : PH_IDLE;
   end

   assign run_w  = (phase_q == PH_RUN);
   assign clr_w  = !en_i;
   assign load_w = !run_w || period_end_w;

   bl_pwm_cfg_shadow #(
      .PRE_W(PRE_W), .PN_W(PN_W), .ZERO_PRE_AS_ONE(ZERO_PRE_AS_ONE)
   ) u_shadow (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_w),
      .pre_i(pre_i), .pn_i(pn_i), .pn_min_i(pn_min_i), .pn_max_i(pn_max_i),
      .duty_i(duty_i),
      .pre_q(pre_q), .pn_q(pn_q), .top_q(top_q), .duty_q(duty_q)
   );

   bl_pwm_prediv #(.PRE_W(PRE_W)) u_prediv (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_w), .run_i(run_w),
      .modulus_i(pre_q), .tick_o(tick_w), .at_zero_o(pre_zero_w)
   );

   bl_pwm_step #(.RES_W(RES_W)) u_step (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_w), .run_i(run_w),
      .tick_i(tick_w), .top_i(top_q), .duty_i(duty_q),
      .wrap_o(period_end_w), .at_zero_o(step_zero_w), .high_o(pwm_o)
   );

   assign strobe_o = run_w && pre_zero_w && step_zero_w;
endmodule

// File: rtl/bl_pwm_gen_chk.sv
module bl_pwm_gen_chk #(
   parameter int PRE_W           = 8,
   parameter int PN_W            = 5,
   parameter bit ZERO_PRE_AS_ONE = 1'b1,
   localparam int RES_W          = (1 << PN_W) - 1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             en_i,
   input logic             pwm_o,
   input logic             strobe_o,
   input logic             run_w,
   input logic             period_end_w,
   input logic [PRE_W-1:0] pre_q,
   input logic [PN_W-1:0]  pn_q,
   input logic [RES_W-1:0] duty_q
);
   // R7: a low enable silences both outputs on the next cycle
   a_r7_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!pwm_o && !strobe_o));

   // R1: the end of a period is followed by a period-start strobe
   a_r1_strobe_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w && period_end_w && en_i) |=> strobe_o);

   // R6: shadow settings hold while a period is under way
   a_r6_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w && !period_end_w) |=> ($stable(pre_q) && $stable(pn_q) && $stable(duty_q)));

   // R5: a zero duty level never drives the pin high
   a_r5_zero_duty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (duty_q == '0) |-> !pwm_o);

   // R2: the applied pre-divider is never zero
   a_r2_pre_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ZERO_PRE_AS_ONE || pre_q != '0));

   // R7: the pin is only high while running
   a_r7_high_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwm_o |-> run_w);
endmodule

bind bl_pwm_gen bl_pwm_gen_chk #(
   .PRE_W(PRE_W), .PN_W(PN_W), .ZERO_PRE_AS_ONE(ZERO_PRE_AS_ONE)
) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .pwm_o(pwm_o),
   .strobe_o(strobe_o), .run_w(run_w), .period_end_w(period_end_w),
   .pre_q(pre_q), .pn_q(pn_q), .duty_q(duty_q)
);

// File: tb/bl_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module bl_pwm_gen_tb_top;
   localparam int PRE_W = 8;
   localparam int PN_W  = 5;
   localparam int RES_W = (1 << PN_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [PRE_W-1:0] pre = '0;
   logic [PN_W-1:0]  pn = '0;
   logic [PN_W-1:0]  pn_min = '0;
   logic [PN_W-1:0]  pn_max = '0;
   logic [RES_W-1:0] duty = '0;
   logic             pwm;
   logic             strobe;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   bl_pwm_gen #(.PRE_W(PRE_W), .PN_W(PN_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pre_i(pre), .pn_i(pn),
      .pn_min_i(pn_min), .pn_max_i(pn_max), .duty_i(duty),
      .pwm_o(pwm), .strobe_o(strobe)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int eff_pn(input int p, input int mn, input int mx);
      int v = (p > mx) ? mx : p;
      return (v < mn) ? mn : v;
   endfunction

   task automatic apply(input int f, input int p, input int mn, input int mx, input int d);
      pre = PRE_W'(f); pn = PN_W'(p); pn_min = PN_W'(mn); pn_max = PN_W'(mx);
      duty = RES_W'(d);
   endtask

   // called on a strobe cycle; returns on the next strobe cycle
   task automatic one_period(output int per, output int hi);
      per = 0; hi = 0;
      do begin
         hi += int'(pwm);
         per++;
         @(negedge clk);
      end while (!strobe && per < 20000);
   endtask

   task automatic start_run();
      @(negedge clk); en = 1'b1;
      @(negedge clk);
   endtask

   task automatic scen_basic(input string req, input int f, input int p, input int mn,
                             input int mx, input int d);
      int pe, fe, exp_per, exp_hi, per, hi;
      pe = eff_pn(p, mn, mx);
      fe = (f == 0) ? 1 : f;
      exp_per = fe << pe;
      exp_hi  = (d & ((1 << pe) - 1)) * fe;
      @(negedge clk); en = 1'b0; apply(f, p, mn, mx, d);
      repeat (3) @(negedge clk);
      start_run();
      check(strobe == 1'b1, {req, " R7 start strobe"}, int'(strobe), 1);
      for (int k = 0; k < 2; k++) begin
         one_period(per, hi);
         check(per == exp_per, {req, " period"}, per, exp_per);
         check(hi == exp_hi, {req, " high"}, hi, exp_hi);
      end
      en = 1'b0;
   endtask

   task automatic scen_midchange();
      int per, hi;
      @(negedge clk); en = 1'b0; apply(2, 2, 0, 31, 1);
      repeat (2) @(negedge clk);
      start_run();
      apply(3, 3, 0, 31, 2);     // written after the period-start edge
      one_period(per, hi);
      check(per == 8, "R6 old period kept", per, 8);
      check(hi == 2, "R6 old high kept", hi, 2);
      one_period(per, hi);
      check(per == 24, "R6 new period", per, 24);
      check(hi == 6, "R6 new high", hi, 6);
      en = 1'b0;
   endtask

   task automatic scen_disable();
      int seen, per, hi;
      @(negedge clk); en = 1'b0; apply(4, 3, 0, 31, 7);
      repeat (2) @(negedge clk);
      start_run();
      repeat (5) @(negedge clk);
      check(pwm == 1'b1, "R7 running high", int'(pwm), 1);
      en = 1'b0;
      seen = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         seen += int'(pwm) + int'(strobe);
      end
      check(seen == 0, "R7 quiet while disabled", seen, 0);
      apply(1, 2, 0, 31, 3);
      start_run();
      check(strobe == 1'b1, "R7 restart strobe", int'(strobe), 1);
      one_period(per, hi);
      check(per == 4 && hi == 3, "R7 restart uses new settings", per * 100 + hi, 403);
      en = 1'b0;
   endtask

   initial begin
      #15000000;
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(pwm == 1'b0 && strobe == 1'b0, "R9 outputs in reset", int'(pwm) + int'(strobe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pwm == 1'b0 && strobe == 1'b0, "R9 outputs after reset", int'(pwm) + int'(strobe), 0);

      scen_basic("R1 R4 f3 pn2 d1", 3, 2, 0, 31, 1);       // 12 / 3
      scen_basic("R4 f5 pn3 d5", 5, 3, 0, 31, 5);          // 40 / 25
      scen_basic("R2 zero prediv", 0, 2, 0, 31, 2);        // 4 / 2
      scen_basic("R3 raise to min", 2, 1, 3, 6, 7);        // 16 / 14
      scen_basic("R3 R5 lower to max full", 1, 9, 1, 4, 32'h7FFF_FFFF); // 16 / 15
      scen_basic("R3 crossed bounds", 1, 3, 5, 2, 3);      // 32 / 3
      scen_basic("R5 zero duty", 2, 3, 0, 31, 0);          // 16 / 0
      scen_basic("R8 zero bits", 7, 0, 0, 31, 1);          // 7 / 0
      scen_midchange();
      scen_disable();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule